// File: doc/BRIEF.md
# DMA Byte Lane Steering Unit

This block sits between the one-byte DMA data path of a serial peripheral and a system bus two bytes wide. It is used while the peripheral is bus master. Every DMA transfer carries exactly one byte. When the byte goes out toward memory, the block drives it on both bus lanes. External address decode and strobe logic can then store it at an odd or an even location.

When the byte comes in from memory, the block takes it from the low lane by default. A two-bit configuration word can turn on lane swapping. With swapping on, the lane is chosen from address bit 0 of the transfer, and a polarity bit decides which lane carries even addresses. The block samples address bit 0 when the transfer starts. It registers the incoming byte on the completion strobe and raises a valid pulse for one cycle.

Top module: `dma_lane_steer`

## Requirements
- R1: While reset is held and in the first cycle after it, busOe is 0, busOut is 0, rxValid is 0 and rxByte is 0. Both configuration bits are 0 after reset.
- R2: While a transfer with xferToMem=1 is active, busOe is 1, busOut[7:0] equals txByte and busOut[15:8] equals txByte, in the same cycle as txByte.
- R3: With swap enable 0, a byte taken from memory always comes from busIn[7:0], whatever address bit 0 is.
- R4: On a clock edge where xferDone is 1 and an inbound transfer (xferToMem=0) is active, rxByte takes the selected lane. In the following cycle rxValid is 1 for exactly one cycle. At all other times rxByte holds its value.
- R5: With swap enable 1 and swap select 1, an even address (A0=0) is taken from busIn[7:0] and an odd address (A0=1) from busIn[15:8].
- R6: With swap enable 1 and swap select 0, an even address is taken from busIn[15:8] and an odd address from busIn[7:0].
- R7: A clock edge with cfgWe=1 loads cfgWord: bit 1 is swap enable and bit 0 is swap select. The lane choice of a transfer uses the configuration held before its start edge.
- R8: Address bit 0 is sampled on the start edge. Changes to dmaAddr0 later in the transfer do not alter the captured lane.
- R9: When no outbound transfer is active, busOe is 0 and busOut is 0. This covers inbound transfers and the idle state.
- R10: xferStart while a transfer is active is ignored. xferDone while idle is ignored and produces no rxValid.
- R11: A transfer starts on an edge where xferStart is 1 while idle, and ends on an edge where xferDone is 1 while active. After an outbound transfer ends, busOe is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWord | input | 2 | Bit 1 swap enable, bit 0 swap select |
| xferStart | input | 1 | Begins a transfer when idle |
| xferToMem | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| dmaAddr0 | input | 1 | Bit 0 of the DMA address |
| xferDone | input | 1 | Transfer-complete strobe |
| txByte | input | 8 | Byte sent toward memory |
| busIn | input | 16 | System bus data read from memory |
| busOut | output | 16 | System bus data driven toward memory |
| busOe | output | 1 | Output enable for busOut |
| rxByte | output | 8 | Captured incoming byte |
| rxValid | output | 1 | One-cycle pulse after a capture |

## Verification
Each kind of internal fault shows at the ports as soon as it is exercised:
- A wrong lane flag appears as a wrong rxByte in the cycle right after completion, and only for address and configuration combinations that select the other lane. The bench therefore covers all eight combinations of swap enable, swap select and address bit 0.
- A stale or missing active flag shows as busOe wrong in the very next cycle, or as a missing or extra rxValid pulse.
- A configuration bit loaded at the wrong time only affects the transfer that starts right after the write, so the bench places writes next to start edges.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic driveEn;   // outbound transfer active: drive bus
    logic captureEn; // inbound completion this cycle
    logic laneHigh;  // take incoming byte from upper lane
  } steerCtl_t;

  // configuration bit positions
  localparam int CFG_SEL_BIT = 0;
  localparam int CFG_EN_BIT  = 1;
  localparam int CFG_W       = 2;
endpackage

// File: rtl/dma_lane_ctl.sv
module dma_lane_ctl
  import lane_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             xferStart,
  input  logic             xferToMem,
  input  logic             dmaAddr0,
  input  logic             xferDone,
  output steerCtl_t        ctl
);
  logic [CFG_W-1:0] cfgReg;
  logic active;
  logic toMem;
  logic laneHighReg;
  logic acceptStart;
  logic acceptDone;
  logic laneFromAddr;

  assign acceptStart = !active && xferStart;
  assign acceptDone  = active && xferDone;

  // polarity select: sel=1 puts odd bytes high, sel=0 puts even bytes high
  assign laneFromAddr = cfgReg[CFG_EN_BIT] &
                        (cfgReg[CFG_SEL_BIT] ? dmaAddr0 : ~dmaAddr0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg      <= '0;
      active      <= 1'b0;
      toMem       <= 1'b0;
      laneHighReg <= 1'b0;
    end else begin
      if (cfgWe) cfgReg <= cfgWord;
      if (acceptStart) begin
        active      <= 1'b1;
        toMem       <= xferToMem;
        laneHighReg <= laneFromAddr;
      end else if (acceptDone) begin
        active <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.driveEn   = active && toMem;
    ctl.captureEn = acceptDone && !toMem;
    ctl.laneHigh  = laneHighReg;
  end
endmodule

// File: rtl/dma_lane_dp.sv
module dma_lane_dp
  import lane_steer_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 2,
  localparam int BUS_W    = LANE_W * NUM_LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerCtl_t         ctl,
  input  logic [LANE_W-1:0] txByte,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  output logic [LANE_W-1:0] rxByte,
  output logic              rxValid
);
  logic [LANE_W-1:0] laneIn [NUM_LANES];
  logic [LANE_W-1:0] pickedByte;

  // replicate the outbound byte on every lane and slice the inbound lanes
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign busOut[g*LANE_W +: LANE_W] = ctl.driveEn ? txByte : '0;
    assign laneIn[g] = busIn[g*LANE_W +: LANE_W];
  end

  assign busOe      = ctl.driveEn;
  assign pickedByte = ctl.laneHigh ? laneIn[NUM_LANES-1] : laneIn[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= ctl.captureEn;
      if (ctl.captureEn) rxByte <= pickedByte;
    end
  end
endmodule

// File: rtl/dma_lane_steer.sv
module dma_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CFG_W-1:0]    cfgWord,
  input  logic                xferStart,
  input  logic                xferToMem,
  input  logic                dmaAddr0,
  input  logic                xferDone,
  input  logic [LANE_W-1:0]   txByte,
  input  logic [2*LANE_W-1:0] busIn,
  output logic [2*LANE_W-1:0] busOut,
  output logic                busOe,
  output logic [LANE_W-1:0]   rxByte,
  output logic                rxValid
);
  steerCtl_t ctl;

  dma_lane_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWord(cfgWord),
    .xferStart(xferStart), .xferToMem(xferToMem), .dmaAddr0(dmaAddr0),
    .xferDone(xferDone), .ctl(ctl)
  );

  dma_lane_dp #(.LANE_W(LANE_W), .NUM_LANES(2)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txByte(txByte), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .rxByte(rxByte), .rxValid(rxValid)
  );
endmodule

// File: rtl/dma_lane_steer_chk.sv
module dma_lane_steer_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                xferDone,
  input logic [LANE_W-1:0]   txByte,
  input logic [2*LANE_W-1:0] busOut,
  input logic                busOe,
  input logic [LANE_W-1:0]   rxByte,
  input logic                rxValid
);
  assert_dup_lanes_R2: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (busOut[2*LANE_W-1:LANE_W] == txByte && busOut[LANE_W-1:0] == txByte));

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> busOut == '0);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_hold_byte_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> (rxValid || $stable(rxByte)));

  assert_valid_after_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(xferDone));

  assert_end_drive_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && xferDone) |=> !busOe);
endmodule

bind dma_lane_steer dma_lane_steer_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .xferDone(xferDone), .txByte(txByte),
  .busOut(busOut), .busOe(busOe), .rxByte(rxByte), .rxValid(rxValid)
);

// File: tb/tb_dma_lane_steer.sv
module tb_dma_lane_steer;
  logic clk = 0;
  logic rstN = 0;
  logic cfgWe = 0;
  logic [1:0] cfgWord = 0;
  logic xferStart = 0, xferToMem = 0, dmaAddr0 = 0, xferDone = 0;
  logic [7:0] txByte = 0;
  logic [15:0] busIn = 0;
  logic [15:0] busOut;
  logic busOe;
  logic [7:0] rxByte;
  logic rxValid;

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";

  // reference model state
  bit mAct, mDir, mHigh, mValid, mEn, mSel;
  byte unsigned mRx;
  string capTag = "R4";

  always #5 clk = ~clk;

  dma_lane_steer dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWord(cfgWord),
    .xferStart(xferStart), .xferToMem(xferToMem), .dmaAddr0(dmaAddr0),
    .xferDone(xferDone), .txByte(txByte), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .rxByte(rxByte), .rxValid(rxValid)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mAct = 0; mDir = 0; mHigh = 0; mValid = 0; mRx = 0; mEn = 0; mSel = 0;
    end else begin
      mValid = mAct && !mDir && xferDone;
      if (mValid) begin
        mRx = mHigh ? busIn[15:8] : busIn[7:0];
        if (!mEn) capTag = "R3";
        else if (mSel) capTag = "R5";
        else capTag = "R6";
      end
      if (!mAct && xferStart) begin
        mAct = 1; mDir = xferToMem;
        mHigh = mEn && (mSel ? dmaAddr0 : !dmaAddr0);
      end else if (mAct && xferDone) mAct = 0;
      if (cfgWe) begin mEn = cfgWord[1]; mSel = cfgWord[0]; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) cycle %0d: actual %0h expected %0h", tag, phase, cyc, act, exp);
    end
  endtask

  task automatic compareAll();
    bit eOe;
    eOe = mAct && mDir;
    chk(eOe ? "R2" : "R9", busOe, eOe);
    chk(eOe ? "R2" : "R9", busOut, eOe ? {txByte, txByte} : 16'h0);
    chk("R4", rxValid, mValid);
    chk(capTag, rxByte, mRx);
  endtask

  task automatic step(bit st, bit dir, bit a0, bit dn, byte unsigned tx,
                      logic [15:0] bi, bit we, logic [1:0] cw);
    @(negedge clk);
    xferStart = st; xferToMem = dir; dmaAddr0 = a0; xferDone = dn;
    txByte = tx; busIn = bi; cfgWe = we; cfgWord = cw;
    #1 compareAll();
  endtask

  task automatic inbound(bit a0, logic [15:0] bi);
    step(1, 0, a0, 0, 8'h00, 16'h0, 0, 2'b00);
    step(0, 0, a0, 0, 8'h00, 16'h0, 0, 2'b00);
    step(0, 0, a0, 1, 8'h00, bi, 0, 2'b00);
    step(0, 0, 0, 0, 8'h00, 16'h0, 0, 2'b00);
    step(0, 0, 0, 0, 8'h00, 16'h0, 0, 2'b00);
  endtask

  initial begin
    fork
      begin
        phase = "R1";
        repeat (3) step(0, 0, 0, 0, 8'h5A, 16'hFFFF, 0, 2'b11);
        chk("R1", busOe, 0); chk("R1", rxValid, 0); chk("R1", rxByte, 0);
        @(negedge clk); rstN = 1;
        step(0, 0, 0, 0, 8'h00, 16'h0, 0, 2'b00);
        chk("R1", busOut, 0);

        phase = "R2";
        step(1, 1, 0, 0, 8'hA5, 16'h0, 0, 2'b00);
        step(0, 1, 0, 0, 8'h3C, 16'h0, 0, 2'b00);
        step(0, 1, 1, 1, 8'hC3, 16'h0, 0, 2'b00);
        phase = "R11";
        step(0, 0, 0, 0, 8'h77, 16'h0, 0, 2'b00);
        chk("R11", busOe, 0);

        phase = "R3";
        inbound(0, 16'hBEEF); chk("R3", rxByte, 8'hEF);
        inbound(1, 16'h1234); chk("R3", rxByte, 8'h34);

        phase = "R7";
        step(0, 0, 0, 0, 0, 16'h0, 1, 2'b11);
        phase = "R5";
        inbound(0, 16'hAB12); chk("R5", rxByte, 8'h12);
        inbound(1, 16'hAB12); chk("R5", rxByte, 8'hAB);
        phase = "R6";
        step(0, 0, 0, 0, 0, 16'h0, 1, 2'b10);
        inbound(0, 16'hCD34); chk("R6", rxByte, 8'hCD);
        inbound(1, 16'hCD34); chk("R6", rxByte, 8'h34);

        phase = "R7";
        // write in the same cycle as start: old config (en=1 sel=0) applies
        step(1, 0, 0, 0, 0, 16'h0, 1, 2'b00);
        step(0, 0, 0, 1, 0, 16'h9876, 0, 2'b00);
        step(0, 0, 0, 0, 0, 16'h0, 0, 2'b00);
        chk("R7", rxByte, 8'h98);

        phase = "R8";
        step(0, 0, 0, 0, 0, 16'h0, 1, 2'b11);
        step(1, 0, 1, 0, 0, 16'h0, 0, 2'b00);
        step(0, 0, 0, 0, 0, 16'h0, 0, 2'b00);
        step(0, 0, 0, 1, 0, 16'h6655, 0, 2'b00);
        step(0, 0, 0, 0, 0, 16'h0, 0, 2'b00);
        chk("R8", rxByte, 8'h66);

        phase = "R10";
        step(0, 0, 0, 1, 0, 16'hFFFF, 0, 2'b00);
        step(0, 0, 0, 0, 0, 16'h0, 0, 2'b00);
        chk("R10", rxValid, 0); chk("R10", rxByte, 8'h66);
        step(1, 1, 0, 0, 8'h11, 16'h0, 0, 2'b00);
        step(1, 0, 0, 0, 8'h22, 16'h0, 0, 2'b00);
        chk("R10", busOe, 1);
        step(0, 0, 0, 1, 8'h33, 16'hAAAA, 0, 2'b00);
        step(0, 0, 0, 0, 8'h44, 16'h0, 0, 2'b00);
        chk("R10", rxValid, 0);

        phase = "R4";
        for (int i = 0; i < 3000; i++)
          step($urandom % 3 == 0, $urandom % 2, $urandom % 2, $urandom % 3 == 0,
               $urandom, $urandom, $urandom % 8 == 0, $urandom);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule